// File: doc/BRIEF.md
# UART Interrupt Source Arbiter

This block gathers every interrupt cause of a 16550-style serial port and presents the most urgent one as a 4-bit identification code, together with a single interrupt request line. The causes are: receive line errors, receive data at or above the FIFO trigger level, character timeout, transmit holding register empty, and modem line changes. Each cause except receive data is held in its own pending flag. Software clears a flag by the register access that belongs to that cause.

The causes are masked by a 4-bit enable word before arbitration. Masking a cause hides it from the code and from the request line, but its pending flag still records events. The code and the request line are combinational from the pending flags, the FIFO level and the enables. A flag that is set at a clock edge is therefore reported in the cycle that follows. When a set and a clear arrive in the same cycle, the set wins, so no event is lost.

Top module: `uart_int_ident`

## Requirements
- R1: With no enabled cause pending, `int_id` is 4'b0001 and `irq` is 0. In every cycle `irq` equals the inverse of `int_id[0]`.
- R2: A high level on any of `err_overrun`, `err_parity`, `err_framing` or `err_break` during a cycle sets the line-error flag at that clock edge. The flag is reported as 4'b0110, which has the highest priority.
- R3: The line-error flag is cleared by `rd_lsr`. If a new error arrives in the same cycle as `rd_lsr`, the flag stays set.
- R4: Receive data is reported as 4'b0100 while `rx_level` is at least the trigger depth. `trig_sel` encodes that depth: 00 is 1, 01 is 4, 10 is 8 and 11 is 14. The indication follows the level without being latched.
- R5: A `char_timeout` pulse sets the timeout flag, which is reported as 4'b1100. A `rd_rbr` clears it.
- R6: A rising edge of `thr_empty` sets the transmit-empty flag, which is reported as 4'b0010. A `wr_thr` clears it.
- R7: `rd_iir` clears the transmit-empty flag only when the code being reported in that cycle is 4'b0010. Otherwise it has no effect on the flag.
- R8: A high bit on `msr_delta` (bits: CTS, DSR, RI, DCD changes) sets the modem flag, which is reported as 4'b0000. A `rd_msr` clears it.
- R9: The bits of `int_enable` mask the causes: bit 0 receive data and timeout, bit 1 transmit empty, bit 2 line error, bit 3 modem. A masked flag keeps its state and is reported once it is enabled again.
- R10: The priority order, from highest to lowest, is line error, receive data, timeout, transmit empty, modem.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_overrun | input | 1 | Receiver overrun seen |
| err_parity | input | 1 | Parity error seen |
| err_framing | input | 1 | Framing error seen |
| err_break | input | 1 | Break condition seen |
| rx_level | input | LVL_W | Receive FIFO fill level |
| trig_sel | input | 2 | Receive trigger select |
| char_timeout | input | 1 | Character timeout pulse |
| thr_empty | input | 1 | Transmit holding register empty level |
| msr_delta | input | 4 | Modem line change flags |
| int_enable | input | 4 | Per-cause enable mask |
| rd_lsr | input | 1 | Line status read strobe |
| rd_rbr | input | 1 | Receive buffer read strobe |
| rd_iir | input | 1 | Identification read strobe |
| wr_thr | input | 1 | Holding register write strobe |
| rd_msr | input | 1 | Modem status read strobe |
| int_id | output | 4 | Identification code of the top cause |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions check some rules in every cycle. These are the idle code and the request polarity, how line errors and modem changes set their flags and how the strobes clear them, the receive-data report at or above the trigger depth, and the rule that an identification read clears transmit-empty only when transmit-empty is the reported cause. Some behaviours only show up over a sequence of steps, so only the bench's scenarios can exercise them. These include the full ordering when several causes are pending at once, the point where timeout gives way to receive data as the level crosses the trigger, and a masked flag coming back once it is enabled. The bench scenarios also check that a new edge re-arms transmit-empty and that each trigger encoding gives the right threshold.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [3:0] {
        ID_MODEM   = 4'b0000,
        ID_NONE    = 4'b0001,
        ID_THRE    = 4'b0010,
        ID_RXDATA  = 4'b0100,
        ID_LINE    = 4'b0110,
        ID_TIMEOUT = 4'b1100
    } irq_id_e;

    typedef struct packed {
        logic line;
        logic rxdata;
        logic timeout;
        logic thre;
        logic modem;
    } irq_src_t;

    typedef struct packed {
        logic modem;
        logic line;
        logic thre;
        logic rxdata;
    } irq_en_t;

    localparam int unsigned TRIG_SEL_W = 2;
    localparam int unsigned ERR_W      = 4;
    localparam int unsigned MSR_W      = 4;

    function automatic int unsigned trig_depth(input logic [TRIG_SEL_W-1:0] sel);
        case (sel)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

    function automatic irq_id_e prio_pick(input irq_src_t s);
        if (s.line)         return ID_LINE;
        else if (s.rxdata)  return ID_RXDATA;
        else if (s.timeout) return ID_TIMEOUT;
        else if (s.thre)    return ID_THRE;
        else if (s.modem)   return ID_MODEM;
        else                return ID_NONE;
    endfunction

endpackage

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky #(
    parameter int unsigned SET_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] set_vec,
    input  logic             clr,
    output logic             pend
);
    logic hit;
    assign hit = |set_vec;

    always_ff @(posedge clk) begin
        if (rst)
            pend <= 1'b0;
        else if (hit)
            pend <= 1'b1;
        else if (clr)
            pend <= 1'b0;
    end
endmodule

// File: rtl/uart_irq_thre.sv
module uart_irq_thre (
    input  logic clk,
    input  logic rst,
    input  logic thr_empty,
    input  logic wr_thr,
    input  logic rd_iir,
    input  logic thre_reported,
    output logic pend
);
    logic empty_q;
    logic rise;
    logic clr;

    assign rise = thr_empty & ~empty_q;
    assign clr  = wr_thr | (rd_iir & thre_reported);

    always_ff @(posedge clk) begin
        if (rst) begin
            empty_q <= 1'b0;
            pend    <= 1'b0;
        end else begin
            empty_q <= thr_empty;
            if (rise)
                pend <= 1'b1;
            else if (clr)
                pend <= 1'b0;
        end
    end

    assert_iir_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_iir && thre_reported && !rise) |=> !pend);

    assert_iir_keep_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_iir && !thre_reported && !wr_thr && pend) |=> pend);

    assert_write_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_thr && !rise) |=> !pend);
endmodule

// File: rtl/uart_irq_rxlevel.sv
module uart_irq_rxlevel
    import uart_irq_pkg::*;
#(
    parameter int unsigned LVL_W = 5
) (
    input  logic [LVL_W-1:0]      rx_level,
    input  logic [TRIG_SEL_W-1:0] trig_sel,
    output logic                  at_trigger
);
    logic [LVL_W-1:0] depth;

    assign depth      = LVL_W'(trig_depth(trig_sel));
    assign at_trigger = (rx_level >= depth);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  irq_src_t src,
    output irq_id_e  id
);
    always_comb id = prio_pick(src);
endmodule

// File: rtl/uart_int_ident.sv
module uart_int_ident
    import uart_irq_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 16,
    parameter int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             err_overrun,
    input  logic             err_parity,
    input  logic             err_framing,
    input  logic             err_break,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [1:0]       trig_sel,
    input  logic             char_timeout,
    input  logic             thr_empty,
    input  logic [3:0]       msr_delta,
    input  logic [3:0]       int_enable,
    input  logic             rd_lsr,
    input  logic             rd_rbr,
    input  logic             rd_iir,
    input  logic             wr_thr,
    input  logic             rd_msr,
    output logic [3:0]       int_id,
    output logic             irq
);
    logic [ERR_W-1:0] err_vec;
    logic             line_pend;
    logic             tmo_pend;
    logic             thre_pend;
    logic             modem_pend;
    logic             at_trigger;
    irq_en_t          en;
    irq_src_t         masked;
    irq_id_e          id;

    assign err_vec = {err_break, err_framing, err_parity, err_overrun};
    assign en      = irq_en_t'(int_enable);

    uart_irq_sticky #(.SET_W(ERR_W)) u_line (
        .clk(clk), .rst(rst), .set_vec(err_vec), .clr(rd_lsr), .pend(line_pend));

    uart_irq_sticky #(.SET_W(1)) u_tmo (
        .clk(clk), .rst(rst), .set_vec(char_timeout), .clr(rd_rbr), .pend(tmo_pend));

    uart_irq_sticky #(.SET_W(MSR_W)) u_modem (
        .clk(clk), .rst(rst), .set_vec(msr_delta), .clr(rd_msr), .pend(modem_pend));

    uart_irq_thre u_thre (
        .clk(clk), .rst(rst), .thr_empty(thr_empty), .wr_thr(wr_thr),
        .rd_iir(rd_iir), .thre_reported(id == ID_THRE), .pend(thre_pend));

    uart_irq_rxlevel #(.LVL_W(LVL_W)) u_level (
        .rx_level(rx_level), .trig_sel(trig_sel), .at_trigger(at_trigger));

    always_comb begin
        masked.line    = line_pend  & en.line;
        masked.rxdata  = at_trigger & en.rxdata;
        masked.timeout = tmo_pend   & en.rxdata;
        masked.thre    = thre_pend  & en.thre;
        masked.modem   = modem_pend & en.modem;
    end

    uart_irq_prio u_prio (.src(masked), .id(id));

    assign int_id = id;
    assign irq    = ~id[0];

    // Checker state: becomes 1 after the first clock out of reset.
    logic chk_armed;
    always_ff @(posedge clk) begin
        if (rst) chk_armed <= 1'b0;
        else     chk_armed <= 1'b1;
    end

    assert_idle_code_R1: assert property (@(posedge clk) disable iff (rst)
        (masked == '0) |-> (int_id == 4'b0001 && !irq));

    assert_line_set_R2: assert property (@(posedge clk) disable iff (rst)
        (chk_armed && $past(|err_vec) && int_enable[2]) |-> (int_id == 4'b0110));

    assert_line_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (chk_armed && $past(rd_lsr && !(|err_vec)) && int_enable == 4'b0100) |-> (int_id == 4'b0001));

    assert_rxdata_R4: assert property (@(posedge clk) disable iff (rst)
        (at_trigger && int_enable[0] && !(line_pend && int_enable[2])) |-> (int_id == 4'b0100));

    assert_timeout_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (chk_armed && $past(rd_rbr && !char_timeout) && int_enable == 4'b0001 && !at_trigger)
            |-> (int_id == 4'b0001));

    assert_modem_set_R8: assert property (@(posedge clk) disable iff (rst)
        (chk_armed && $past(|msr_delta) && int_enable == 4'b1000) |-> (int_id == 4'b0000));

    assert_all_masked_R9: assert property (@(posedge clk) disable iff (rst)
        (int_enable == 4'b0000) |-> (int_id == 4'b0001 && !irq));
endmodule

// File: tb/uart_int_ident_test.sv
`timescale 1ns/1ps
module uart_int_ident_test;
    localparam int unsigned LVL_W = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic err_overrun = 0, err_parity = 0, err_framing = 0, err_break = 0;
    logic [LVL_W-1:0] rx_level = '0;
    logic [1:0] trig_sel = 2'b00;
    logic char_timeout = 0, thr_empty = 0;
    logic [3:0] msr_delta = '0;
    logic [3:0] int_enable = 4'hF;
    logic rd_lsr = 0, rd_rbr = 0, rd_iir = 0, wr_thr = 0, rd_msr = 0;
    logic [3:0] int_id;
    logic irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;
    logic [3:0] exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    uart_int_ident uut (
        .clk(clk), .rst(rst),
        .err_overrun(err_overrun), .err_parity(err_parity),
        .err_framing(err_framing), .err_break(err_break),
        .rx_level(rx_level), .trig_sel(trig_sel), .char_timeout(char_timeout),
        .thr_empty(thr_empty), .msr_delta(msr_delta), .int_enable(int_enable),
        .rd_lsr(rd_lsr), .rd_rbr(rd_rbr), .rd_iir(rd_iir), .wr_thr(wr_thr),
        .rd_msr(rd_msr), .int_id(int_id), .irq(irq));

    // Driver: pulses are {err[3:0] = brk,frm,par,ovr}, strobes = {lsr,rbr,iir,thr,msr}
    task automatic step(input logic [3:0] err, input logic tmo, input logic [3:0] msr,
                        input logic [4:0] strb, input logic [3:0] exp, input string tag);
        @(negedge clk);
        {err_break, err_framing, err_parity, err_overrun} = err;
        char_timeout = tmo;
        msr_delta = msr;
        {rd_lsr, rd_rbr, rd_iir, wr_thr, rd_msr} = strb;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        {err_break, err_framing, err_parity, err_overrun} = '0;
        char_timeout = 0;
        msr_delta = '0;
        {rd_lsr, rd_rbr, rd_iir, wr_thr, rd_msr} = '0;
    endtask

    task automatic idle(input logic [3:0] exp, input string tag);
        step(4'b0, 1'b0, 4'b0, 5'b0, exp, tag);
    endtask

    // Monitor: compares one expected code per clock, just after the edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [3:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_run++;
            if (int_id !== e || irq !== ~e[0]) begin
                n_fail++;
                $display("FAIL %s: int_id=%b irq=%b expected int_id=%b irq=%b",
                         t, int_id, irq, e, ~e[0]);
            end
        end
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        n_run++;
        if (int_id !== 4'b0001 || irq !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset: int_id=%b irq=%b expected 0001 0", int_id, irq);
        end
        idle(4'b0001, "R1 idle");
        // Line errors
        step(4'b0001, 0, 4'b0, 5'b0, 4'b0110, "R2 overrun sets");
        idle(4'b0110, "R2 sticky");
        step(4'b0, 0, 4'b0, 5'b10000, 4'b0001, "R3 lsr read clears");
        step(4'b1000, 0, 4'b0, 5'b10000, 4'b0110, "R3 set wins over read");
        step(4'b0, 0, 4'b0, 5'b10000, 4'b0001, "R3 clear again");
        // Receive level vs trigger
        rx_level = 1; trig_sel = 2'b00;
        idle(4'b0100, "R4 depth1 at 1");
        rx_level = 3; trig_sel = 2'b01;
        idle(4'b0001, "R4 depth4 at 3");
        rx_level = 4;
        idle(4'b0100, "R4 depth4 at 4");
        rx_level = 13; trig_sel = 2'b11;
        idle(4'b0001, "R4 depth14 at 13");
        rx_level = 14;
        idle(4'b0100, "R4 depth14 at 14");
        rx_level = 8; trig_sel = 2'b10;
        idle(4'b0100, "R4 depth8 at 8");
        rx_level = 7;
        idle(4'b0001, "R4 depth8 at 7");
        // Timeout
        step(4'b0, 1, 4'b0, 5'b0, 4'b1100, "R5 timeout sets");
        rx_level = 8;
        idle(4'b0100, "R10 rxdata over timeout");
        rx_level = 7;
        idle(4'b1100, "R5 timeout still pending");
        step(4'b0, 0, 4'b0, 5'b01000, 4'b0001, "R5 rbr read clears");
        rx_level = 0;
        // Transmit empty
        thr_empty = 1;
        idle(4'b0010, "R6 rising edge sets");
        idle(4'b0010, "R6 sticky");
        step(4'b0, 0, 4'b0, 5'b00010, 4'b0001, "R6 thr write clears");
        idle(4'b0001, "R6 no re-arm while high");
        thr_empty = 0;
        idle(4'b0001, "R6 low");
        thr_empty = 1;
        idle(4'b0010, "R6 re-armed");
        step(4'b0010, 0, 4'b0, 5'b0, 4'b0110, "R10 line over thre");
        step(4'b0, 0, 4'b0, 5'b00100, 4'b0110, "R7 iir read while line reported");
        step(4'b0, 0, 4'b0, 5'b10000, 4'b0010, "R7 thre survived iir read");
        step(4'b0, 0, 4'b0, 5'b00100, 4'b0001, "R7 iir read clears thre");
        // Modem
        step(4'b0, 0, 4'b0100, 5'b0, 4'b0000, "R8 modem change sets");
        step(4'b0, 0, 4'b0, 5'b00001, 4'b0001, "R8 msr read clears");
        // Masks
        int_enable = 4'b1011;
        step(4'b0100, 0, 4'b0, 5'b0, 4'b0001, "R9 line masked");
        int_enable = 4'hF;
        idle(4'b0110, "R9 line unmasked");
        step(4'b0, 0, 4'b0, 5'b10000, 4'b0001, "R9 line cleared");
        int_enable = 4'b0111;
        step(4'b0, 0, 4'b0001, 5'b0, 4'b0001, "R9 modem masked");
        int_enable = 4'hF;
        idle(4'b0000, "R9 modem unmasked");
        step(4'b0, 0, 4'b0, 5'b00001, 4'b0001, "R9 modem cleared");
        // Full ordering
        thr_empty = 0;
        idle(4'b0001, "R10 thre low");
        thr_empty = 1;
        idle(4'b0010, "R10 thre pending");
        step(4'b0, 0, 4'b1000, 5'b0, 4'b0010, "R10 thre over modem");
        step(4'b0, 1, 4'b0, 5'b0, 4'b1100, "R10 timeout over thre");
        step(4'b0001, 0, 4'b0, 5'b0, 4'b0110, "R10 line over timeout");
        step(4'b0, 0, 4'b0, 5'b10000, 4'b1100, "R10 timeout next");
        step(4'b0, 0, 4'b0, 5'b01000, 4'b0010, "R10 thre next");
        step(4'b0, 0, 4'b0, 5'b00010, 4'b0000, "R10 modem next");
        step(4'b0, 0, 4'b0, 5'b00001, 4'b0001, "R1 back to idle");
        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule